// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits between a framebuffer fetch path and a display timing path. Every accepted pixel word is cut into red, green and blue fields, each widened to an 8-bit byte. Four configuration words, held steady by the surrounding logic, set the layout. A format word gives how many bytes of the 32-bit pixel word are meaningful, and the bytes above that count are forced to zero. Each colour has a select word that gives the bit position where the field starts, its width from 0 to 15 bits, and a fallback byte.

The fallback byte is sent in place of the extracted value in three cases: the field width is zero, the pixel lies outside the visible area, or the fetch path flagged an underrun for that pixel. If the red fallback is set to 0xFF, missed pixels show up as red. Fields narrower than 8 bits are placed at the top of the byte, and their own bits are repeated downward to fill the low bits. Fields wider than 8 bits keep their top 8 bits.

Pixels enter and leave through valid/ready handshakes, with one register stage between the two sides. A result that is not accepted stays on the outputs, unchanged, until the consumer takes it. The input side takes a new pixel in any cycle where the output register is empty or is being emptied in that same cycle, so back-pressure reaches the producer in the cycle it is applied.

Top module: `pce_color_extract`

## Requirements
- R1: Format word bits [4:3] hold the number of meaningful bytes minus one (0 means 1 byte, 3 means 4 bytes). Pixel-word bytes at or above that count read as zero before any field is extracted.
- R2: Select word bits [4:0] give the index of the field's lowest bit in the pixel word. Field bits that fall above bit 31 read as zero.
- R3: Select word bits [11:8] give the field width. A width from 1 to 8 fills the output byte MSB-first with the field, and the field's bits repeat from its top bit until all 8 output bits are filled.
- R4: A field width from 9 to 15 outputs the top 8 bits of the extracted field.
- R5: A colour whose width is zero outputs its fallback byte, taken from select word bits [23:16].
- R6: A pixel whose active-area flag is low outputs the fallback byte for all three colours.
- R7: A pixel whose underrun flag is high outputs the fallback byte for all three colours.
- R8: An accepted pixel appears on the outputs with out_valid high in the next cycle. Results leave in the order the pixels were accepted, none is lost and none is duplicated.
- R9: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and the colour outputs hold their values.
- R10: During reset, out_valid and all colour outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_cfg | input | 32 | Format word (bytes-per-pixel minus one at [4:3]) |
| red_cfg | input | 32 | Red select word |
| grn_cfg | input | 32 | Green select word |
| blu_cfg | input | 32 | Blue select word |
| in_valid | input | 1 | Pixel word offered |
| in_ready | output | 1 | Pixel word accepted when high with in_valid |
| in_word | input | 32 | Pixel word from the framebuffer |
| in_active | input | 1 | Pixel lies inside the visible area |
| in_underrun | input | 1 | Pixel data arrived too late |
| out_valid | output | 1 | Colour bytes present |
| out_ready | input | 1 | Consumer takes the colour bytes |
| out_red | output | 8 | Red byte |
| out_grn | output | 8 | Green byte |
| out_blu | output | 8 | Blue byte |

## Verification
Fallback substitution and output back-pressure can act in the same cycle. A blanked or underrun pixel may arrive while the output register is stalled, and the stalled pixel may itself carry a fallback value. The random phase holds out_ready low for runs of cycles while the active-area flag, the underrun flag and the widths, which are sometimes zero, change from pixel to pixel. The held outputs must stay equal to the values captured when the stall began. Each pixel that is released later must match the model value computed from the configuration in force when that pixel was accepted.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int COMP_W      = 8;
  localparam int CFG_W       = 32;
  localparam int FMT_BPP_LSB = 3;
  localparam int SEL_OFF_LSB = 0;
  localparam int SEL_OFF_W   = 5;
  localparam int SEL_LEN_LSB = 8;
  localparam int SEL_LEN_W   = 4;
  localparam int SEL_DEF_LSB = 16;

  typedef struct packed {
    logic [COMP_W-1:0]    dflt;
    logic [SEL_LEN_W-1:0] len;
    logic [SEL_OFF_W-1:0] off;
  } comp_sel_t;

  typedef struct packed {
    logic [COMP_W-1:0] red;
    logic [COMP_W-1:0] grn;
    logic [COMP_W-1:0] blu;
  } rgb_t;

  function automatic comp_sel_t decode_sel(input logic [CFG_W-1:0] r);
    comp_sel_t s;
    s.off  = r[SEL_OFF_LSB +: SEL_OFF_W];
    s.len  = r[SEL_LEN_LSB +: SEL_LEN_W];
    s.dflt = r[SEL_DEF_LSB +: COMP_W];
    return s;
  endfunction
endpackage

// File: rtl/pce_byte_mask.sv
module pce_byte_mask #(
  parameter int WORD_W = 32,
  localparam int NB    = WORD_W / 8,
  localparam int CNT_W = $clog2(NB)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  bytes_m1,
  output logic [WORD_W-1:0] masked
);
  // a byte lane survives only when it lies below the programmed count
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign masked[g*8 +: 8] = (CNT_W'(g) <= bytes_m1) ? word[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pce_field_expand.sv
module pce_field_expand #(
  parameter int WORD_W = 32,
  parameter int COMP_W = 8,
  parameter int OFF_W  = 5,
  parameter int LEN_W  = 4,
  localparam int FLD_W = 2 ** LEN_W,
  localparam int REP_W = COMP_W * COMP_W,
  localparam int SH_W  = $clog2(REP_W + 1)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  output logic [COMP_W-1:0] comp
);
  logic [WORD_W-1:0] shifted;
  logic [FLD_W-1:0]  lmask;
  logic [FLD_W-1:0]  fld;
  logic [REP_W-1:0]  rep;
  logic [COMP_W-1:0] short_v;
  logic [COMP_W-1:0] long_v;
  logic              unused_high;

  always_comb begin
    shifted = word >> off;
    lmask   = FLD_W'(((FLD_W+1)'(1) << len) - (FLD_W+1)'(1));
    fld     = shifted[FLD_W-1:0] & lmask;
    // stack copies of a short field until the byte is covered, then take the top
    rep = '0;
    for (int k = 0; k < COMP_W; k++) begin
      rep = (rep << len) | REP_W'(fld[COMP_W-1:0]);
    end
    short_v = COMP_W'(rep >> (SH_W'(COMP_W) * SH_W'(len) - SH_W'(COMP_W)));
    long_v  = COMP_W'(fld >> (len - LEN_W'(COMP_W)));
    comp    = (len >= LEN_W'(COMP_W)) ? long_v : short_v;
  end

  assign unused_high = ^shifted[WORD_W-1:FLD_W];
endmodule

// File: rtl/pce_lane.sv
module pce_lane
  import pce_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  comp_sel_t         sel,
  input  logic              blank,
  output logic [COMP_W-1:0] comp
);
  logic [COMP_W-1:0] raw;

  pce_field_expand #(
    .WORD_W(WORD_W),
    .COMP_W(COMP_W),
    .OFF_W (SEL_OFF_W),
    .LEN_W (SEL_LEN_W)
  ) i_expand (
    .word(word),
    .off (sel.off),
    .len (sel.len),
    .comp(raw)
  );

  assign comp = (blank || sel.len == '0) ? sel.dflt : raw;
endmodule

// File: rtl/pce_color_extract.sv
module pce_color_extract
  import pce_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int NB    = WORD_W / 8,
  localparam int CNT_W = $clog2(NB),
  localparam int NCOMP = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     fmt_cfg,
  input  logic [CFG_W-1:0]     red_cfg,
  input  logic [CFG_W-1:0]     grn_cfg,
  input  logic [CFG_W-1:0]     blu_cfg,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WORD_W-1:0]    in_word,
  input  logic                 in_active,
  input  logic                 in_underrun,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [COMP_W-1:0]    out_red,
  output logic [COMP_W-1:0]    out_grn,
  output logic [COMP_W-1:0]    out_blu
);
  logic [CFG_W-1:0]  cfg_arr  [NCOMP];
  logic [COMP_W-1:0] comp_arr [NCOMP];
  logic [WORD_W-1:0] masked;
  logic              blank;
  logic              accept;
  logic              valid_q;
  rgb_t              pix_d, pix_q;
  logic              unused_cfg;

  assign cfg_arr[0] = red_cfg;
  assign cfg_arr[1] = grn_cfg;
  assign cfg_arr[2] = blu_cfg;

  assign unused_cfg = ^{fmt_cfg[CFG_W-1:FMT_BPP_LSB+CNT_W], fmt_cfg[FMT_BPP_LSB-1:0],
                        red_cfg[CFG_W-1:SEL_DEF_LSB+COMP_W], red_cfg[SEL_DEF_LSB-1:SEL_LEN_LSB+SEL_LEN_W],
                        red_cfg[SEL_LEN_LSB-1:SEL_OFF_LSB+SEL_OFF_W],
                        grn_cfg[CFG_W-1:SEL_DEF_LSB+COMP_W], grn_cfg[SEL_DEF_LSB-1:SEL_LEN_LSB+SEL_LEN_W],
                        grn_cfg[SEL_LEN_LSB-1:SEL_OFF_LSB+SEL_OFF_W],
                        blu_cfg[CFG_W-1:SEL_DEF_LSB+COMP_W], blu_cfg[SEL_DEF_LSB-1:SEL_LEN_LSB+SEL_LEN_W],
                        blu_cfg[SEL_LEN_LSB-1:SEL_OFF_LSB+SEL_OFF_W]};

  pce_byte_mask #(.WORD_W(WORD_W)) i_mask (
    .word    (in_word),
    .bytes_m1(fmt_cfg[FMT_BPP_LSB +: CNT_W]),
    .masked  (masked)
  );

  assign blank = !in_active || in_underrun;

  for (genvar g = 0; g < NCOMP; g++) begin : g_comp
    pce_lane #(.WORD_W(WORD_W)) i_lane (
      .word (masked),
      .sel  (decode_sel(cfg_arr[g])),
      .blank(blank),
      .comp (comp_arr[g])
    );
  end

  assign pix_d.red = comp_arr[0];
  assign pix_d.grn = comp_arr[1];
  assign pix_d.blu = comp_arr[2];

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) pix_q <= pix_d;
    end
  end

  assign out_valid = valid_q;
  assign out_red   = pix_q.red;
  assign out_grn   = pix_q.grn;
  assign out_blu   = pix_q.blu;

  // R8: an accepted pixel is presented in the following cycle
  a_r8_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R9: a stalled result neither drops nor changes
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_red) && $stable(out_grn) && $stable(out_blu)));

  // R5: zero red width yields the red fallback
  a_r5_zero_len_default: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && red_cfg[SEL_LEN_LSB +: SEL_LEN_W] == '0) |=> out_red == $past(red_cfg[SEL_DEF_LSB +: COMP_W]));

  // R6: outside the visible area green takes its fallback
  a_r6_blank_default: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_active) |=> out_grn == $past(grn_cfg[SEL_DEF_LSB +: COMP_W]));

  // R7: an underrun pixel gives the blue fallback
  a_r7_underrun_default: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_underrun) |=> out_blu == $past(blu_cfg[SEL_DEF_LSB +: COMP_W]));
endmodule

// File: tb/test_pce_color_extract.sv
`timescale 1ns/1ps
module test_pce_color_extract;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fmt_cfg, red_cfg, grn_cfg, blu_cfg;
  logic        in_valid, in_ready, in_active, in_underrun;
  logic [31:0] in_word;
  logic        out_valid, out_ready;
  logic [7:0]  out_red, out_grn, out_blu;

  int errors = 0;
  int checks = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic        hold_prev = 1'b0;
  logic [23:0] held;

  always #2.5 clk = ~clk;

  pce_color_extract i_pce_color_extract (
    .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg), .red_cfg(red_cfg), .grn_cfg(grn_cfg),
    .blu_cfg(blu_cfg), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .in_active(in_active), .in_underrun(in_underrun), .out_valid(out_valid),
    .out_ready(out_ready), .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu));

  function automatic logic [31:0] mk_sel(input int off, input int len, input int dflt);
    return (32'(dflt & 255) << 16) | (32'(len & 15) << 8) | 32'(off & 31);
  endfunction

  function automatic logic [7:0] ref_comp(input logic [31:0] w, input logic [31:0] f,
                                          input logic [31:0] s, input logic act, input logic und);
    int nbytes = int'(f[4:3]) + 1;
    int off = int'(s[4:0]);
    int len = int'(s[11:8]);
    logic [31:0] m = w;
    logic [15:0] fb = '0;
    logic [7:0]  res;
    if (len == 0 || !act || und) return s[23:16];
    for (int b = 0; b < 4; b++) if (b >= nbytes) m[b*8 +: 8] = 8'h00;
    for (int k = 0; k < len; k++) fb[k] = (off + k < 32) ? m[off + k] : 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (len >= 8) res[i] = fb[len - 8 + i];
      else res[i] = fb[len - 1 - ((7 - i) % len)];
    end
    return res;
  endfunction

  function automatic string pick_tag(input logic [31:0] f, input logic act, input logic und);
    if (und) return "R7";
    if (!act) return "R6";
    if (red_cfg[11:8] == 0 || grn_cfg[11:8] == 0 || blu_cfg[11:8] == 0) return "R5";
    if (int'(red_cfg[4:0]) + int'(red_cfg[11:8]) > 32) return "R2";
    if (red_cfg[11:8] > 8 || grn_cfg[11:8] > 8 || blu_cfg[11:8] > 8) return "R4";
    if (f[4:3] != 2'd3) return "R1";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [31:0] w, input logic act, input logic und,
                       input logic [31:0] f, input logic [31:0] r, input logic [31:0] g,
                       input logic [31:0] b, input logic rdy);
    @(negedge clk);
    in_valid = v; in_word = w; in_active = act; in_underrun = und;
    fmt_cfg = f; red_cfg = r; grn_cfg = g; blu_cfg = b; out_ready = rdy;
    #1;
    if (hold_prev)
      check(out_valid && {out_red, out_grn, out_blu} == held, "R9", "stalled output changed",
            {7'd0, out_valid, out_red, out_grn, out_blu}, {8'h01, held});
    if (out_valid && !out_ready) begin
      if (!hold_prev) check(!in_ready, "R9", "in_ready during stall", 32'(in_ready), 32'd0);
      hold_prev = 1'b1;
      held = {out_red, out_grn, out_blu};
    end else hold_prev = 1'b0;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R8", "output with nothing accepted", 32'd1, 32'd0);
      else begin
        logic [23:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        check({out_red, out_grn, out_blu} == e, t, "colour bytes",
              {8'd0, out_red, out_grn, out_blu}, {8'd0, e});
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back({ref_comp(w, f, r, act, und), ref_comp(w, f, g, act, und),
                       ref_comp(w, f, b, act, und)});
      tag_q.push_back(pick_tag(f, act, und));
    end
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 0; in_word = 0; in_active = 0; in_underrun = 0;
    fmt_cfg = 0; red_cfg = 0; grn_cfg = 0; blu_cfg = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && {out_red, out_grn, out_blu} == 24'd0, "R10", "reset state",
          {7'd0, out_valid, out_red, out_grn, out_blu}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R8: single pixel latency
    cycle(1, 32'h00F8_1F00, 1, 0, 32'h18, mk_sel(16, 8, 0), mk_sel(8, 8, 0), mk_sel(0, 8, 0), 1);
    check(!out_valid, "R8", "valid too early", 32'(out_valid), 32'd0);
    cycle(0, 0, 1, 0, 32'h18, 0, 0, 0, 1);
    check(out_valid, "R8", "valid one cycle after accept", 32'(out_valid), 32'd1);
    cycle(0, 0, 1, 0, 32'h18, 0, 0, 0, 1);
    check(!out_valid, "R8", "valid cleared after take", 32'(out_valid), 32'd0);

    // R1: one meaningful byte, upper bytes vanish
    cycle(1, 32'hAABB_CCDD, 1, 0, 32'h00, mk_sel(8, 8, 8'h11), mk_sel(0, 8, 0), mk_sel(24, 8, 0), 1);
    // R3: 5-6-5 packing in two bytes
    cycle(1, 32'h0000_F81F, 1, 0, 32'h08, mk_sel(11, 5, 0), mk_sel(5, 6, 0), mk_sel(0, 5, 0), 1);
    cycle(1, 32'h0000_A5B5, 1, 0, 32'h08, mk_sel(13, 3, 0), mk_sel(5, 6, 0), mk_sel(0, 1, 0), 1);
    // R4: wide field keeps its top byte
    cycle(1, 32'h000A_BC00, 1, 0, 32'h18, mk_sel(8, 12, 0), mk_sel(4, 15, 0), mk_sel(0, 9, 0), 1);
    // R2: field running off the top of the word
    cycle(1, 32'hF000_0000, 1, 0, 32'h18, mk_sel(28, 8, 0), mk_sel(31, 2, 0), mk_sel(30, 4, 0), 1);
    // R5: zero widths
    cycle(1, 32'h1234_5678, 1, 0, 32'h18, mk_sel(0, 0, 8'h5A), mk_sel(8, 0, 8'hC3), mk_sel(4, 8, 0), 1);
    // R6: outside visible area
    cycle(1, 32'h1234_5678, 0, 0, 32'h18, mk_sel(0, 8, 8'h01), mk_sel(8, 8, 8'h02), mk_sel(16, 8, 8'h03), 1);
    // R7: underrun shows red
    cycle(1, 32'hFFFF_FFFF, 1, 1, 32'h18, mk_sel(0, 8, 8'hFF), mk_sel(8, 8, 8'h00), mk_sel(16, 8, 8'h00), 1);
    // R9: stall then release
    cycle(1, 32'h0102_0304, 1, 0, 32'h18, mk_sel(0, 8, 0), mk_sel(8, 8, 0), mk_sel(16, 8, 0), 0);
    cycle(1, 32'h0506_0708, 1, 0, 32'h18, mk_sel(0, 8, 0), mk_sel(8, 8, 0), mk_sel(16, 8, 0), 0);
    cycle(1, 32'h0506_0708, 0, 1, 32'h18, mk_sel(0, 8, 7), mk_sel(8, 8, 8), mk_sel(16, 8, 9), 0);
    cycle(1, 32'h0506_0708, 1, 0, 32'h18, mk_sel(0, 8, 0), mk_sel(8, 8, 0), mk_sel(16, 8, 0), 1);
    cycle(0, 0, 1, 0, 32'h18, 0, 0, 0, 1);
    cycle(0, 0, 1, 0, 32'h18, 0, 0, 0, 1);

    // random phase: mixed stalls, blanking, underruns and layouts
    for (int n = 0; n < 4000; n++) begin
      cycle(($urandom % 10) < 7, $urandom, ($urandom % 8) != 0, ($urandom % 10) == 0,
            $urandom, $urandom, $urandom, $urandom, ($urandom % 10) < 6);
    end

    for (int n = 0; n < 8; n++) cycle(0, 0, 1, 0, 0, 0, 0, 0, 1);
    check(exp_q.size() == 0, "R8", "results still owed", 32'(exp_q.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule